// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block produces instruction fetch addresses for a small core whose instruction words are 14 bits wide. It keeps a 13-bit program counter, which starts at the reset vector. Each clock cycle the counter can stay where it is, step by one, load a branch target, enter a subroutine, return from one, or move to the interrupt vector. Subroutine entry and interrupt entry save the address of the next instruction on an eight-entry hardware return stack. Each return takes the most recent saved address back off that stack. Software cannot read or write the stack as data.

The commands are one-hot single-cycle strobes from the instruction decoder: `cmd_inc`, `cmd_jump`, `cmd_call`, `cmd_ret` and `cmd_irq`. A single `cmd_ret` serves plain returns, interrupt returns and returns that carry a literal. The full 13-bit counter is visible on `pc_out`. The fetch address sent to the program memory keeps only the low log2(`IMPL_WORDS`) bits of the counter. Program memory is 512 or 1024 words, so the unimplemented upper counter bits alias onto the same word.

A two-state sequence controller gates the commands. After reset it is in `ST_VECTOR`, where the counter holds the reset vector and every command is ignored. On the first clock edge after reset is released it takes the transition VECTOR_TO_RUN into `ST_RUN`. It stays in `ST_RUN` (the RUN_STAY transition) until the next reset. In `ST_RUN` an arbiter turns the strobes into one operation: OP_HOLD, OP_INC, OP_JUMP, OP_CALL, OP_RET or OP_IRQ.

Top module: `prog_seq`

## Requirements
- R1: While reset is asserted, `pc_out` and `fetch_addr` are 0. On the first rising clock edge after reset is released, all commands are ignored and `pc_out` stays at 0.
- R2: With only `cmd_inc` asserted, `pc_out` becomes the old value plus one after the clock edge. The value 1FFFh steps to 0000h.
- R3: With only `cmd_jump` asserted, `pc_out` becomes `target_addr` after the clock edge.
- R4: `cmd_call` saves `pc_out`+1 on the return stack and loads `target_addr`. A later `cmd_ret` loads the saved address back into `pc_out`.
- R5: `cmd_irq` saves `pc_out`+1 on the return stack and loads 0004h. A later `cmd_ret` resumes at the saved address.
- R6: When several strobes are asserted in the same cycle, exactly one takes effect. The priority, highest first, is `cmd_irq`, `cmd_call`, `cmd_ret`, `cmd_jump`, `cmd_inc`.
- R7: Up to eight nested saves come back in last-in first-out order.
- R8: The stack is circular and raises no flag. A ninth save overwrites the oldest entry. After nine saves, eight returns give the nine most recent addresses except the oldest, newest first. A ninth return then wraps and gives the newest address again.
- R9: When no strobe is asserted, `pc_out` and the stack keep their values.
- R10: `fetch_addr` equals `pc_out` modulo `IMPL_WORDS`. With 1024 words, the counter values 020h, 420h, 820h, C20h, 1020h, 1420h, 1820h and 1C20h all give a `fetch_addr` of 020h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_inc | input | 1 | Step to the next sequential address |
| cmd_jump | input | 1 | Load `target_addr` |
| cmd_call | input | 1 | Save next address on the stack, then load `target_addr` |
| cmd_ret | input | 1 | Load the most recent saved address from the stack |
| cmd_irq | input | 1 | Save next address on the stack, then load the interrupt vector |
| target_addr | input | 13 | Branch or call destination |
| pc_out | output | 13 | Full program counter |
| fetch_addr | output | log2(IMPL_WORDS) | Physical program memory address |

## Verification
The assertions check on every cycle the transitions that are local in time. They cover the hold in `ST_VECTOR`, the single step, the jump load and the interrupt vector. They also check that the stack pointer moves by exactly one on each save and return and stays put when no strobe is asserted. Only the bench scenarios can show that the correct address comes back after a chain of nested calls, that the oldest entry is the one overwritten on overflow, that a return past empty wraps, and that all eight mirror addresses land on the same physical word.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic {
        ST_VECTOR = 1'b0,
        ST_RUN    = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_INC  = 3'd1,
        OP_JUMP = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_IRQ  = 3'd5
    } seq_op_e;

endpackage

// File: rtl/prog_seq_arb.sv
module prog_seq_arb
    import prog_seq_pkg::*;
(
    input  logic    run,
    input  logic    cmd_inc,
    input  logic    cmd_jump,
    input  logic    cmd_call,
    input  logic    cmd_ret,
    input  logic    cmd_irq,
    output seq_op_e op
);

    // Fixed priority: interrupt, call, return, jump, step.
    always_comb begin
        op = OP_HOLD;
        if (run) begin
            if (cmd_irq)       op = OP_IRQ;
            else if (cmd_call) op = OP_CALL;
            else if (cmd_ret)  op = OP_RET;
            else if (cmd_jump) op = OP_JUMP;
            else if (cmd_inc)  op = OP_INC;
        end
    end

endmodule

// File: rtl/prog_seq_stack.sv
module prog_seq_stack #(
    parameter  int AW    = 13,
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [AW-1:0]    push_data,
    output logic [AW-1:0]    top_data,
    output logic [PTR_W-1:0] ptr
);

    logic [AW-1:0]    slot_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_dec;

    // Pointer names the next free slot; it wraps silently in both directions.
    assign ptr_dec  = ptr_q - 1'b1;
    assign top_data = slot_q[ptr_dec];
    assign ptr      = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (push) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (pop) begin
            ptr_q <= ptr_dec;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[gi] <= '0;
            end else if (push && (ptr_q == PTR_W'(gi))) begin
                slot_q[gi] <= push_data;
            end
        end
    end

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter  int          PC_W        = 13,
    parameter  int          IMPL_WORDS  = 1024,
    parameter  int          STACK_DEPTH = 8,
    parameter  logic [12:0] RESET_VEC   = 13'h0000,
    parameter  logic [12:0] IRQ_VEC     = 13'h0004,
    localparam int          IMPL_W      = $clog2(IMPL_WORDS),
    localparam int          PTR_W       = $clog2(STACK_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_inc,
    input  logic              cmd_jump,
    input  logic              cmd_call,
    input  logic              cmd_ret,
    input  logic              cmd_irq,
    input  logic [PC_W-1:0]   target_addr,
    output logic [PC_W-1:0]   pc_out,
    output logic [IMPL_W-1:0] fetch_addr
);

    seq_state_e       state_q, state_d;
    seq_op_e          op;
    logic             run_q;
    logic [PC_W-1:0]  pc_q, pc_d, pc_next_seq;
    logic             stk_push, stk_pop;
    logic [PC_W-1:0]  stk_top;
    logic [PTR_W-1:0] stk_ptr;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_VECTOR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_VECTOR: state_d = ST_RUN;   // VECTOR_TO_RUN
            ST_RUN:    state_d = ST_RUN;   // RUN_STAY
        endcase
    end

    assign run_q = (state_q == ST_RUN);

    prog_seq_arb u_arb (
        .run      (run_q),
        .cmd_inc  (cmd_inc),
        .cmd_jump (cmd_jump),
        .cmd_call (cmd_call),
        .cmd_ret  (cmd_ret),
        .cmd_irq  (cmd_irq),
        .op       (op)
    );

    assign pc_next_seq = pc_q + 1'b1;

    // Output process: next counter value and stack controls.
    always_comb begin
        pc_d     = pc_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        unique case (op)
            OP_HOLD: pc_d = pc_q;
            OP_INC:  pc_d = pc_next_seq;
            OP_JUMP: pc_d = target_addr;
            OP_CALL: begin
                pc_d     = target_addr;
                stk_push = 1'b1;
            end
            OP_RET: begin
                pc_d    = stk_top;
                stk_pop = 1'b1;
            end
            OP_IRQ: begin
                pc_d     = PC_W'(IRQ_VEC);
                stk_push = 1'b1;
            end
            default: pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= PC_W'(RESET_VEC);
        else        pc_q <= pc_d;
    end

    prog_seq_stack #(
        .AW    (PC_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (pc_next_seq),
        .top_data  (stk_top),
        .ptr       (stk_ptr)
    );

    assign pc_out     = pc_q;
    assign fetch_addr = pc_q[IMPL_W-1:0];

endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
    parameter int PC_W   = 13,
    parameter int IMPL_W = 10,
    parameter int PTR_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_inc,
    input logic              cmd_jump,
    input logic              cmd_call,
    input logic              cmd_ret,
    input logic              cmd_irq,
    input logic [PC_W-1:0]   target_addr,
    input logic [PC_W-1:0]   pc_out,
    input logic [IMPL_W-1:0] fetch_addr,
    input logic              run,
    input logic [PTR_W-1:0]  sp
);

    logic only_inc, only_jump, no_cmd;
    assign only_inc  = cmd_inc && !cmd_jump && !cmd_call && !cmd_ret && !cmd_irq;
    assign only_jump = cmd_jump && !cmd_call && !cmd_ret && !cmd_irq;
    assign no_cmd    = !cmd_inc && !cmd_jump && !cmd_call && !cmd_ret && !cmd_irq;

    p_vector_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> pc_out == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run && only_inc |=> pc_out == PC_W'($past(pc_out) + 1'b1));

    p_jump_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && only_jump |=> pc_out == $past(target_addr));

    p_call_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && cmd_call && !cmd_irq |=> (sp == PTR_W'($past(sp) + 1'b1))
                                        && (pc_out == $past(target_addr)));

    p_irq_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run && cmd_irq |=> (pc_out == PC_W'(13'h0004))
                           && (sp == PTR_W'($past(sp) + 1'b1)));

    p_ret_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run && cmd_ret && !cmd_call && !cmd_irq |=> sp == PTR_W'($past(sp) - 1'b1));

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run && no_cmd |=> $stable(pc_out) && $stable(sp));

    p_fetch_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run && only_inc |=> fetch_addr == IMPL_W'($past(fetch_addr) + 1'b1));

endmodule

bind prog_seq prog_seq_chk #(
    .PC_W   (PC_W),
    .IMPL_W (IMPL_W),
    .PTR_W  (PTR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_inc     (cmd_inc),
    .cmd_jump    (cmd_jump),
    .cmd_call    (cmd_call),
    .cmd_ret     (cmd_ret),
    .cmd_irq     (cmd_irq),
    .target_addr (target_addr),
    .pc_out      (pc_out),
    .fetch_addr  (fetch_addr),
    .run         (run_q),
    .sp          (stk_ptr)
);

// File: tb/prog_seq_tb.sv
module prog_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IMPL_WORDS = 1024;
    localparam int IMPL_W     = $clog2(IMPL_WORDS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_inc = 1'b0, cmd_jump = 1'b0, cmd_call = 1'b0;
    logic              cmd_ret = 1'b0, cmd_irq = 1'b0;
    logic [12:0]       target_addr = '0;
    logic [12:0]       pc_out;
    logic [IMPL_W-1:0] fetch_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state.
    logic [12:0] m_pc = '0;
    logic [12:0] m_stk [8];
    int          m_sp = 0;

    // Scoreboard.
    logic [12:0] q_pc  [$];
    string       q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_seq #(.IMPL_WORDS(IMPL_WORDS)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_inc     (cmd_inc),
        .cmd_jump    (cmd_jump),
        .cmd_call    (cmd_call),
        .cmd_ret     (cmd_ret),
        .cmd_irq     (cmd_irq),
        .target_addr (target_addr),
        .pc_out      (pc_out),
        .fetch_addr  (fetch_addr)
    );

    task automatic check(input string tag, input logic [12:0] act_pc,
                         input logic [IMPL_W-1:0] act_fa, input logic [12:0] exp_pc);
        logic [IMPL_W-1:0] exp_fa;
        exp_fa = exp_pc[IMPL_W-1:0];
        n_checks++;
        if (act_pc !== exp_pc || act_fa !== exp_fa) begin
            n_fail++;
            $display("FAIL %s: pc=%h fetch=%h expected pc=%h fetch=%h",
                     tag, act_pc, act_fa, exp_pc, exp_fa);
        end
    endtask

    task automatic m_push(input logic [12:0] v);
        m_stk[m_sp] = v;
        m_sp = (m_sp + 1) % 8;
    endtask

    // Driver: apply one cycle of strobes and queue the expected counter.
    task automatic step(input bit i_inc, input bit i_jmp, input bit i_call,
                        input bit i_ret, input bit i_irq,
                        input logic [12:0] tgt, input string tag);
        logic [12:0] nxt;
        @(negedge clk);
        cmd_inc = i_inc; cmd_jump = i_jmp; cmd_call = i_call;
        cmd_ret = i_ret; cmd_irq = i_irq; target_addr = tgt;
        nxt = m_pc + 13'd1;
        if (i_irq) begin
            m_push(nxt); m_pc = 13'h0004;
        end else if (i_call) begin
            m_push(nxt); m_pc = tgt;
        end else if (i_ret) begin
            m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp];
        end else if (i_jmp) begin
            m_pc = tgt;
        end else if (i_inc) begin
            m_pc = nxt;
        end
        q_pc.push_back(m_pc);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare each queued expectation after the edge that produces it.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q_pc.size() > 0) begin
                check(q_tag.pop_front(), pc_out, fetch_addr, q_pc.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run still active, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", pc_out, fetch_addr, 13'h0000);

        // R1: release reset with a step strobe already present; it must be ignored.
        @(negedge clk);
        rst_n = 1'b1; cmd_inc = 1'b1;
        q_pc.push_back(13'h0000); q_tag.push_back("R1 vector cycle");

        // R2 sequential steps
        step(1,0,0,0,0, '0, "R2 step");
        step(1,0,0,0,0, '0, "R2 step");
        step(1,0,0,0,0, '0, "R2 step");
        // R9 idle
        step(0,0,0,0,0, '0, "R9 hold");
        step(0,0,0,0,0, '0, "R9 hold");
        // R3 jump
        step(0,1,0,0,0, 13'h0100, "R3 jump");
        // R4 call and return
        step(0,0,1,0,0, 13'h0200, "R4 call");
        step(1,0,0,0,0, '0, "R4 body step");
        step(0,0,0,1,0, '0, "R4 return");
        // R5 interrupt with a competing step (R6), then return
        step(1,0,0,0,1, '0, "R5 R6 irq over step");
        step(1,0,0,0,0, '0, "R5 handler step");
        step(0,0,0,1,0, '0, "R5 interrupt return");
        // R6 priority combinations
        step(0,1,1,0,0, 13'h0345, "R6 call over jump");
        step(1,1,0,1,0, 13'h0777, "R6 return over jump");
        step(0,0,1,1,1, 13'h0999, "R6 irq over call and return");
        step(0,0,0,1,0, '0, "R6 unwind");
        // R2 wrap at top of address space
        step(0,1,0,0,0, 13'h1FFF, "R3 jump to top");
        step(1,0,0,0,0, '0, "R2 wrap");
        // R7 nested calls to depth eight, then unwind
        for (int k = 0; k < 8; k++)
            step(0,0,1,0,0, 13'(13'h0300 + k*16), "R7 nested call");
        for (int k = 0; k < 8; k++)
            step(0,0,0,1,0, '0, "R7 nested return");
        // R8 nine saves overwrite the oldest; nine returns wrap
        step(0,1,0,0,0, 13'h0040, "R3 jump");
        for (int k = 0; k < 9; k++)
            step(0,0,1,0,0, 13'(13'h0500 + k*32), "R8 overflow call");
        for (int k = 0; k < 9; k++)
            step(0,0,0,1,0, '0, "R8 overflow return");
        // R10 all eight mirrors of 020h map to one physical word
        for (int k = 0; k < 8; k++)
            step(0,1,0,0,0, 13'(k*13'h0400 + 13'h0020), "R10 mirror fetch");
        step(1,0,0,0,0, '0, "R10 step after mirror");
        step(0,0,0,0,0, '0, "R9 final hold");

        @(negedge clk);
        cmd_inc = 0; cmd_jump = 0; cmd_call = 0; cmd_ret = 0; cmd_irq = 0;
        while (q_pc.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule